// File: doc/BRIEF.md
# Per-Device Interrupt Line Router

This block takes one interrupt request from each of several logical devices and places it on one of fifteen shared interrupt lines, numbered 1 to 15. Every device owns a 4-bit line-select register, reached through a small configuration port at register index 0x70. A select of zero parks the device; any other value names the line it drives. A request reaches its line only while the device's own enable condition, computed elsewhere and supplied as an input, is true. Requests that land on the same line are ORed together.

Each line has a drive-enable output for a tri-state pad. The enable is raised only for lines that at least one device has selected, and an undriven line's level is held low. Line 2 shares its pin with an active-low system-management interrupt. While that function is switched on, the pin carries the inverted management request and every device selection of line 2 is masked out.

Both the main reset and the soft reset restore the select defaults: 0x6 for device 0 and 0x0 for all others. Pin outputs are registered, so each line follows its inputs one clock later.

Top module: `irq_line_router`

## Requirements
- R1: A write with `cfg_we` high and `cfg_idx` equal to 0x70 stores `cfg_wdata[3:0]` into the select of device `cfg_dev`; bits 7:4 are dropped. With `cfg_idx` equal to 0x70, `cfg_rdata` returns the select of `cfg_dev` in bits 3:0, with bits 7:4 zero.
- R2: A write at any index other than 0x70 leaves every select unchanged, and `cfg_rdata` reads 0 at such an index.
- R3: While `rst` or `soft_rst` is high at a clock edge, device 0's select becomes 0x6, all other selects become 0x0, and `irq_out` and `irq_oe` become all zero.
- R4: Bit k-1 of `irq_out` and `irq_oe` stands for line k (k from 1 to 15). A device with select k, its request high and its enable high drives `irq_out[k-1]` high one clock later.
- R5: A device whose enable is low does not drive its line, whatever its request.
- R6: Several devices that select the same line are ORed: the line is high if any one of them has both request and enable high.
- R7: `irq_oe[k-1]` is high one clock after some device holds select k, independent of request and enable; otherwise low (line 2 excepted by R9).
- R8: A line whose `irq_oe` bit is low has its `irq_out` bit low.
- R9: While `smi_en` is high, one clock later `irq_oe[1]` is high, `irq_out[1]` equals the inverse of `smi_req`, and device selections of line 2 do not affect that pin.
- R10: A device with select 0x0 drives no line and raises no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high main reset |
| soft_rst | input | 1 | Synchronous active-high soft reset, same effect as `rst` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dev | input | DEV_W | Device selected for configuration access |
| cfg_idx | input | 8 | Register index within the device |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_dev` at `cfg_idx` (combinational) |
| dev_req | input | NUM_DEV | Interrupt request, one per device |
| dev_en | input | NUM_DEV | Device-specific delivery enable, one per device |
| smi_en | input | 1 | Switches the line 2 pin to management interrupt use |
| smi_req | input | 1 | Active-high management interrupt request |
| irq_out | output | 15 | Line levels, bit k-1 is line k |
| irq_oe | output | 15 | Line drive enables, bit k-1 is line k |

## Verification
Request, enable and management inputs show on `irq_out` and `irq_oe` exactly one clock later, a select write shows on the lines two clocks after it is presented (one edge stores it, the next registers the pins), and `cfg_rdata` follows the stored select combinationally right after the storing edge. The bench's model does its line computation at each rising edge with the selects held before that edge's write, then applies the write, and every comparison happens one nanosecond after the edge, once the registers have settled and before new stimulus is driven. Directed phases cover reset defaults, masked upper data bits, foreign indices, shared lines, gated requests and the management pin, followed by a long run of random writes and inputs.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned LINES    = 15;
    localparam int unsigned SEL_W    = 4;
    localparam int unsigned SMI_LINE = 2;
    localparam logic [7:0]  SEL_IDX  = 8'h70;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] oe;
    } pin_bus_t;

endpackage

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_DEV  = 8,
    parameter sel_t        DEV0_DEF = 4'h6,
    parameter int unsigned DEV_W    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_rst,
    input  logic                   wr_en,
    input  logic [DEV_W-1:0]       dev,
    input  logic [7:0]             idx,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    output sel_t [NUM_DEV-1:0]     sel_o
);

    sel_t [NUM_DEV-1:0] sel_q;
    logic               dev_ok;
    logic               hit;
    logic               clr;

    assign dev_ok = (32'(dev) < NUM_DEV);
    assign hit    = wr_en && (idx == SEL_IDX) && dev_ok;
    assign clr    = rst || soft_rst;

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int d = 0; d < int'(NUM_DEV); d++) begin
                sel_q[d] <= (d == 0) ? DEV0_DEF : '0;
            end
        end else if (hit) begin
            sel_q[dev] <= wr_data[SEL_W-1:0];
        end
    end

    assign rd_data = ((idx == SEL_IDX) && dev_ok) ? {{(8-SEL_W){1'b0}}, sel_q[dev]} : 8'h00;
    assign sel_o   = sel_q;

    // R3: defaults after either reset
    a_r3_dev0_default: assert property (@(posedge clk) clr |=> (sel_q[0] == DEV0_DEF));

    generate
        for (genvar d = 1; d < int'(NUM_DEV); d++) begin : g_chk
            a_r3_other_default: assert property (@(posedge clk) clr |=> (sel_q[d] == '0));
        end
    endgenerate

    // R2: foreign index leaves selects alone
    a_r2_foreign_idx: assert property (@(posedge clk) disable iff (clr)
        (wr_en && idx != SEL_IDX) |=> $stable(sel_q));

    // R1: stored nibble visible on the next cycle
    a_r1_store: assert property (@(posedge clk) disable iff (clr)
        hit |=> (sel_q[$past(dev)] == $past(wr_data[SEL_W-1:0])));

endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_DEV = 8
) (
    input  sel_t [NUM_DEV-1:0] sel,
    input  logic [NUM_DEV-1:0] req,
    input  logic [NUM_DEV-1:0] en,
    input  logic               smi_en,
    input  logic               smi_req,
    output pin_bus_t           nxt
);

    logic [NUM_DEV-1:0] live;
    logic [LINES-1:0]   lvl_v;
    logic [LINES-1:0]   oe_v;

    assign live = req & en;

    generate
        for (genvar k = 0; k < int'(LINES); k++) begin : g_line
            localparam bit IS_SMI = ((k + 1) == int'(SMI_LINE));
            logic [NUM_DEV-1:0] picks;
            for (genvar d = 0; d < int'(NUM_DEV); d++) begin : g_dev
                assign picks[d] = (sel[d] == SEL_W'(k + 1));
            end
            if (IS_SMI) begin : g_shared
                assign oe_v[k]  = smi_en | (|picks);
                assign lvl_v[k] = smi_en ? ~smi_req : |(picks & live);
            end else begin : g_plain
                assign oe_v[k]  = |picks;
                assign lvl_v[k] = |(picks & live);
            end
        end
    endgenerate

    assign nxt.lvl = lvl_v;
    assign nxt.oe  = oe_v;

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_DEV  = 8,
    parameter sel_t        DEV0_DEF = 4'h6,
    localparam int unsigned DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               cfg_we,
    input  logic [DEV_W-1:0]   cfg_dev,
    input  logic [7:0]         cfg_idx,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic [NUM_DEV-1:0] dev_en,
    input  logic               smi_en,
    input  logic               smi_req,
    output logic [LINES-1:0]   irq_out,
    output logic [LINES-1:0]   irq_oe
);

    sel_t [NUM_DEV-1:0] sel;
    pin_bus_t           nxt;
    pin_bus_t           pins_q;

    irq_sel_regs #(
        .NUM_DEV  (NUM_DEV),
        .DEV0_DEF (DEV0_DEF),
        .DEV_W    (DEV_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (cfg_we),
        .dev      (cfg_dev),
        .idx      (cfg_idx),
        .wr_data  (cfg_wdata),
        .rd_data  (cfg_rdata),
        .sel_o    (sel)
    );

    irq_merge #(
        .NUM_DEV (NUM_DEV)
    ) u_merge (
        .sel     (sel),
        .req     (dev_req),
        .en      (dev_en),
        .smi_en  (smi_en),
        .smi_req (smi_req),
        .nxt     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            pins_q <= '0;
        end else begin
            pins_q <= nxt;
        end
    end

    assign irq_out = pins_q.lvl;
    assign irq_oe  = pins_q.oe;

    // R8: an undriven line stays low
    a_r8_undriven_low: assert property (@(posedge clk) disable iff (rst)
        ((irq_out & ~irq_oe) == '0));

    // R9: shared pin follows the inverted management request
    a_r9_smi_pin: assert property (@(posedge clk) disable iff (rst || soft_rst)
        smi_en |=> (irq_oe[SMI_LINE-1] && (irq_out[SMI_LINE-1] == !$past(smi_req))));

    // R5: no enable, no line activity
    a_r5_gate_off: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (dev_en == '0 && !smi_en) |=> (irq_out == '0));

    // R7/R10: nothing selected, nothing enabled
    a_r7_no_sel_no_oe: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (sel == '0 && !smi_en) |=> (irq_oe == '0));

endmodule

// File: tb/irq_line_router_tb.sv
module irq_line_router_tb;

    localparam int ND = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_dev = '0;
    logic [7:0]  cfg_idx = 8'h70;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [ND-1:0] dev_req = '0;
    logic [ND-1:0] dev_en = '0;
    logic        smi_en = 1'b0;
    logic        smi_req = 1'b0;
    logic [14:0] irq_out;
    logic [14:0] irq_oe;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string tag = "R3";

    int msel [ND];
    logic [14:0] eo = '0;
    logic [14:0] eoe = '0;

    always #2.5 clk = ~clk;

    irq_line_router u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dev_req(dev_req), .dev_en(dev_en),
        .smi_en(smi_en), .smi_req(smi_req),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    // reference model, evaluated at every rising edge
    always @(posedge clk) begin
        if (rst || soft_rst) begin
            for (int d = 0; d < ND; d++) msel[d] = (d == 0) ? 6 : 0;
            eo = '0;
            eoe = '0;
        end else begin
            eo = '0;
            eoe = '0;
            for (int d = 0; d < ND; d++) begin
                if (msel[d] != 0 && !(smi_en && msel[d] == 2)) begin
                    eoe[msel[d]-1] = 1'b1;
                    if (dev_req[d] && dev_en[d]) eo[msel[d]-1] = 1'b1;
                end
            end
            if (smi_en) begin
                eoe[1] = 1'b1;
                eo[1] = !smi_req;
            end
            if (cfg_we && cfg_idx == 8'h70) msel[cfg_dev] = int'(cfg_wdata & 8'h0F);
        end
    end

    task automatic check_all();
        logic [7:0] er;
        er = (cfg_idx == 8'h70) ? 8'(msel[cfg_dev]) : 8'h00;
        checks++;
        if (irq_out !== eo) begin
            fails++;
            $display("FAIL %s irq_out actual %h expected %h (cycle %0d)", tag, irq_out, eo, cyc);
        end
        checks++;
        if (irq_oe !== eoe) begin
            fails++;
            $display("FAIL %s irq_oe actual %h expected %h (cycle %0d)", tag, irq_oe, eoe, cyc);
        end
        checks++;
        if (cfg_rdata !== er) begin
            fails++;
            $display("FAIL %s cfg_rdata actual %h expected %h (cycle %0d)", tag, cfg_rdata, er, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        check_all();
    endtask

    task automatic wr(input logic [2:0] d, input logic [7:0] ix, input logic [7:0] v);
        cfg_we = 1'b1; cfg_dev = d; cfg_idx = ix; cfg_wdata = v;
        tick();
        cfg_we = 1'b0; cfg_idx = 8'h70;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R3: reset defaults and read-back of every device
        tag = "R3";
        repeat (3) tick();
        rst = 1'b0;
        for (int d = 0; d < ND; d++) begin cfg_dev = 3'(d); tick(); end

        // R1: write with upper bits masked
        tag = "R1";
        wr(3'd1, 8'h70, 8'h53);
        wr(3'd2, 8'h70, 8'h0F);
        wr(3'd3, 8'h70, 8'hA3);
        cfg_dev = 3'd1; tick(); tick();

        // R2: foreign index ignored and reads zero
        tag = "R2";
        wr(3'd1, 8'h71, 8'h09);
        cfg_dev = 3'd1; cfg_idx = 8'h71; tick();
        cfg_idx = 8'h70; tick();

        // R4: single device drives its line
        tag = "R4";
        dev_req = 8'b0000_0100; dev_en = 8'b0000_0100; tick(); tick();

        // R5: enable low blocks the request
        tag = "R5";
        dev_req = 8'hFF; dev_en = 8'h00; tick(); tick();

        // R6: two devices share line 3
        tag = "R6";
        dev_req = 8'b0000_1010; dev_en = 8'b0000_0010; tick();
        dev_en = 8'b0000_1000; tick();
        dev_en = 8'b0000_1010; tick();
        dev_req = 8'h00; tick();

        // R9: management pin masks line 2 selections
        tag = "R9";
        wr(3'd4, 8'h70, 8'h02);
        dev_req = 8'b0001_0000; dev_en = 8'b0001_0000; tick();
        smi_en = 1'b1; smi_req = 1'b0; tick(); tick();
        smi_req = 1'b1; tick(); tick();
        smi_en = 1'b0; tick(); tick();

        // R10: select zero drives nothing
        tag = "R10";
        wr(3'd0, 8'h70, 8'h00);
        wr(3'd4, 8'h70, 8'h00);
        dev_req = 8'h01; dev_en = 8'h01; tick(); tick();

        // R3: soft reset restores defaults
        tag = "R3";
        soft_rst = 1'b1; tick();
        soft_rst = 1'b0; cfg_dev = 3'd0; tick(); tick();

        // R7/R8: random traffic
        tag = "R7";
        for (int i = 0; i < 600; i++) begin
            cfg_we = ($urandom_range(0, 3) == 0);
            cfg_dev = 3'($urandom_range(0, 7));
            cfg_idx = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : 8'h70;
            cfg_wdata = 8'($urandom_range(0, 255));
            dev_req = 8'($urandom_range(0, 255));
            dev_en = 8'($urandom_range(0, 255));
            smi_en = ($urandom_range(0, 4) == 0);
            smi_req = 1'($urandom_range(0, 1));
            soft_rst = ($urandom_range(0, 99) == 0);
            if (i % 2 == 1) tag = "R8"; else tag = "R7";
            tick();
        end
        cfg_we = 1'b0; soft_rst = 1'b0;
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule